// File: doc/BRIEF.md
# Reset and Watchdog Controller with Port-Mapped Control

This block sits on an 8-bit I/O write bus and answers three port offsets above a configurable base address. A write to the soft-reset offset starts a reset that stays on this board. A write to the control offset updates two bits together: the watchdog enable and the DAC output enable. A write to the refresh offset restarts the watchdog count. The block ignores the data written to the soft-reset and refresh offsets.

The external hard reset is synchronised to the clock. It is combined with a one-cycle soft-reset pulse into one local reset. The local reset clears both enable bits. It also drives the strobes that tell neighbouring logic to clear the encoder counters to zero in mode 0 and to switch every relay off. When the watchdog is enabled and no refresh arrives within the timeout, the block drives an active-low output that is meant for the system reset line. That output stays low until the hard reset input is seen. The timeout is a parameter in clock cycles. Its default is 650 ms at 125 MHz.

Top module: `wdog_reset_ctrl`

## Requirements
- R1: A write to offset BASE+11, with any data value, raises `enc_init` and `relay_clr` for exactly one cycle. The pulse starts at the first clock edge after the write is sampled.
- R2: A local reset, whether hard or soft, clears the watchdog enable and the DAC enable. `ctrl_q` then reads 8'h00.
- R3: A soft reset never drives `sys_rst_n` low. It also never releases `sys_rst_n` once it is low.
- R4: A write to offset BASE+12 loads data bit 0 into the watchdog enable and data bit 1 into the DAC enable in the same cycle. `ctrl_q` is {6'b0, DAC enable, watchdog enable}, so its bits 7..2 always read zero. Writes to offsets other than 11, 12 and 15 change nothing.
- R5: A write to offset BASE+15 while the watchdog is enabled restarts the count. It leaves `ctrl_q` unchanged, whatever data it carries.
- R6: With the watchdog enabled and no restart, `sys_rst_n` falls exactly TIMEOUT_CYC clock edges after the edge that restarted the count.
- R7: A control write that turns the watchdog enable from 0 to 1 restarts the count. A control write that leaves the enable at 1 does not restart it. A write that clears the enable zeroes the count.
- R8: While the watchdog is disabled, a refresh write has no effect and `sys_rst_n` never falls.
- R9: After a timeout, `sys_rst_n` stays low until the hard reset input is asserted. It then returns high at the first clock edge of the hard reset.
- R10: `hard_rst_n` low starts the local reset without waiting for a clock edge. `enc_init` and `relay_clr` stay high while the input is low and for one more clock edge after it is released, so they fall at the second edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| hard_rst_n | input | 1 | External hard reset, active low, asynchronous |
| io_wr | input | 1 | Write strobe, one cycle per bus write |
| io_addr | input | ADDR_W | I/O address of the write |
| io_wdata | input | 8 | Write data |
| ctrl_q | output | 8 | Control register value {6'b0, DAC enable, watchdog enable} |
| wdog_en | output | 1 | Watchdog enable bit |
| dac_en | output | 1 | DAC output enable bit |
| enc_init | output | 1 | Local reset strobe: clear encoder counters and select mode 0 |
| relay_clr | output | 1 | Local reset strobe: turn every relay off |
| sys_rst_n | output | 1 | Watchdog timeout reset, active low |

## Verification
The assertions check several rules on every cycle:
- A soft-reset write is always followed by the local reset strobe.
- Every local reset leaves the control register empty.
- The timeout output can fall only when the watchdog was enabled.
- Once low, the timeout output is released only by the synchronised hard reset.
- The count never passes its last value.

Only the bench scenarios can show the exact timeout distance in cycles and the difference between an enabling write and a rewrite of an enabled watchdog. The same holds for a refresh that arrives while the watchdog is disabled and for the D bit surviving writes to the other ports. These need a history of writes and a measured interval, which a single-cycle property does not express.

// File: rtl/wdog_reset_ctrl.sv
module wdog_reset_ctrl #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE = 'h300,
  parameter int TIMEOUT_CYC = 81_250_000,
  localparam int CNT_W = $clog2(TIMEOUT_CYC)
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        ctrl_q,
  output logic              wdog_en,
  output logic              dac_en,
  output logic              enc_init,
  output logic              relay_clr,
  output logic              sys_rst_n
);
  localparam logic [ADDR_W-1:0] A_SOFT = ADDR_W'(BASE + 11);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE + 12);
  localparam logic [ADDR_W-1:0] A_DOG  = ADDR_W'(BASE + 15);
  localparam logic [CNT_W-1:0]  LAST   = CNT_W'(TIMEOUT_CYC - 1);

  logic [1:0] sync;
  logic hard_sync, soft_p, local_rst, fired;
  logic [CNT_W-1:0] cnt;
  logic wr_soft, wr_ctrl, wr_dog, restart, tick;
  logic unused_bits;

  always_ff @(posedge clk or negedge hard_rst_n)
    if (!hard_rst_n) sync <= 2'b00;
    else             sync <= {sync[0], 1'b1};

  assign hard_sync = ~sync[1];
  assign wr_soft   = io_wr && io_addr == A_SOFT;
  assign wr_ctrl   = io_wr && io_addr == A_CTRL;
  assign wr_dog    = io_wr && io_addr == A_DOG;
  assign local_rst = hard_sync | soft_p;

  always_ff @(posedge clk)
    if (hard_sync) soft_p <= 1'b0;
    else           soft_p <= wr_soft;

  always_ff @(posedge clk)
    if (local_rst) begin
      wdog_en <= 1'b0;
      dac_en  <= 1'b0;
    end else if (wr_ctrl) begin
      wdog_en <= io_wdata[0];
      dac_en  <= io_wdata[1];
    end

  assign restart = (wr_ctrl && (io_wdata[0] ? !wdog_en : 1'b1)) || (wr_dog && wdog_en);
  assign tick    = wdog_en && cnt == LAST && !restart && !local_rst;

  always_ff @(posedge clk)
    if (local_rst || restart)                  cnt <= '0;
    else if (wdog_en && !fired && cnt != LAST) cnt <= cnt + 1'b1;

  always_ff @(posedge clk)
    if (hard_sync) fired <= 1'b0;
    else if (tick) fired <= 1'b1;

  assign ctrl_q      = {6'b0, dac_en, wdog_en};
  assign enc_init    = local_rst;
  assign relay_clr   = local_rst;
  assign sys_rst_n   = ~fired;
  assign unused_bits = &{1'b0, io_wdata[7:2]};
endmodule

module wdog_reset_ctrl_chk #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE = 'h300,
  parameter int TIMEOUT_CYC = 81_250_000,
  localparam int CNT_W = $clog2(TIMEOUT_CYC)
) (
  input logic              clk,
  input logic              hard_rst_n,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic              hard_sync,
  input logic              enc_init,
  input logic [7:0]        ctrl_q,
  input logic              wdog_en,
  input logic              sys_rst_n,
  input logic [CNT_W-1:0]  cnt
);
  localparam logic [ADDR_W-1:0] A_SOFT = ADDR_W'(BASE + 11);

  AST_SOFT_STROBE: assert property (@(posedge clk) disable iff (!hard_rst_n)
    io_wr && io_addr == A_SOFT |=> enc_init); // R1
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!hard_rst_n)
    enc_init |=> ctrl_q == 8'h00); // R2
  AST_RELEASE_BY_HARD: assert property (@(posedge clk) disable iff (!hard_rst_n)
    $rose(sys_rst_n) |-> $past(hard_sync)); // R3
  AST_FALL_NEEDS_EN: assert property (@(posedge clk) disable iff (!hard_rst_n)
    $fell(sys_rst_n) |-> $past(wdog_en)); // R8
  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!hard_rst_n)
    !sys_rst_n && !hard_sync |=> !sys_rst_n); // R9
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!hard_rst_n)
    cnt <= CNT_W'(TIMEOUT_CYC - 1)); // R6
endmodule

bind wdog_reset_ctrl wdog_reset_ctrl_chk #(
  .ADDR_W(ADDR_W), .BASE(BASE), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk(clk), .hard_rst_n(hard_rst_n), .io_wr(io_wr), .io_addr(io_addr),
  .hard_sync(hard_sync), .enc_init(enc_init), .ctrl_q(ctrl_q),
  .wdog_en(wdog_en), .sys_rst_n(sys_rst_n), .cnt(cnt)
);

// File: tb/tb_wdog_reset_ctrl.sv
`timescale 1ns/1ps
module tb_wdog_reset_ctrl;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] BASE = 'h300;
  localparam int TO = 40;

  logic clk = 1'b0;
  logic hard_rst_n = 1'b0;
  logic io_wr = 1'b0;
  logic [ADDR_W-1:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] ctrl_q;
  logic wdog_en, dac_en, enc_init, relay_clr, sys_rst_n;

  wdog_reset_ctrl #(.ADDR_W(ADDR_W), .BASE(BASE), .TIMEOUT_CYC(TO)) dut (
    .clk(clk), .hard_rst_n(hard_rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .ctrl_q(ctrl_q), .wdog_en(wdog_en), .dac_en(dac_en),
    .enc_init(enc_init), .relay_clr(relay_clr), .sys_rst_n(sys_rst_n)
  );

  always #4 clk = ~clk;

  typedef struct {
    int due;
    string req;
    int sel;
    logic [7:0] exp;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  int max_due = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pick(int sel);
    case (sel)
      0: return ctrl_q;
      1: return {7'b0, sys_rst_n};
      2: return {7'b0, enc_init};
      default: return {7'b0, relay_clr};
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    for (int i = sb.size() - 1; i >= 0; i--)
      if (sb[i].due == cyc) begin
        logic [7:0] act;
        act = pick(sb[i].sel);
        total++;
        if (act !== sb[i].exp) begin
          bad++;
          $display("FAIL %s cycle %0d sel %0d: actual=%h expected=%h",
                   sb[i].req, cyc, sb[i].sel, act, sb[i].exp);
        end
        sb.delete(i);
      end
  end

  task automatic expect_at(int due, string req, int sel, logic [7:0] e);
    item_t it;
    it.due = due; it.req = req; it.sel = sel; it.exp = e;
    sb.push_back(it);
    if (due > max_due) max_due = due;
  endtask

  task automatic wr(int off, logic [7:0] d, output int c);
    c = cyc;
    io_wr = 1'b1;
    io_addr = ADDR_W'(BASE + off);
    io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic wait_until(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic hard(output int ca, output int cr);
    ca = cyc;
    hard_rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cr = cyc;
    hard_rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: bench hung, actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c, c2, ca, cr;
    repeat (3) @(negedge clk);
    cr = cyc;
    hard_rst_n = 1'b1;
    expect_at(cr + 1, "R10", 2, 8'h01);
    expect_at(cr + 1, "R10", 3, 8'h01);
    expect_at(cr + 2, "R10", 2, 8'h00);
    expect_at(cr + 2, "R2", 0, 8'h00);
    expect_at(cr + 2, "R9", 1, 8'h01);
    repeat (3) @(negedge clk);

    wr(12, 8'hFE, c); expect_at(c + 1, "R4", 0, 8'h02);
    wr(15, 8'hFF, c); expect_at(c + 1, "R5", 0, 8'h02);
    wr(13, 8'hFF, c); expect_at(c + 1, "R4", 0, 8'h02);
    wr(12, 8'hFD, c); expect_at(c + 1, "R4", 0, 8'h01);
    wr(12, 8'h02, c); expect_at(c + 1, "R4", 0, 8'h02);
    repeat (3) @(negedge clk);

    wr(12, 8'h03, c);
    expect_at(c + TO, "R6", 1, 8'h01);
    expect_at(c + TO + 1, "R6", 1, 8'h00);
    expect_at(c + TO + 20, "R9", 1, 8'h00);
    wait_until(c + TO + 22);
    wr(11, 8'h00, c2);
    expect_at(c2 + 2, "R2", 0, 8'h00);
    expect_at(c2 + 6, "R3", 1, 8'h00);
    wait_until(c2 + 8);
    ca = cyc;
    expect_at(ca + 1, "R9", 1, 8'h01);
    hard(ca, cr);

    wr(12, 8'h01, c);
    wait_until(c + 30);
    wr(15, 8'hAA, c2);
    expect_at(c2 + 1, "R5", 0, 8'h01);
    expect_at(c + TO + 1, "R5", 1, 8'h01);
    expect_at(c2 + TO, "R5", 1, 8'h01);
    expect_at(c2 + TO + 1, "R5", 1, 8'h00);
    wait_until(c2 + TO + 3);
    hard(ca, cr);

    wr(12, 8'h01, c);
    wait_until(c + 20);
    wr(12, 8'h03, c2);
    expect_at(c + TO, "R7", 1, 8'h01);
    expect_at(c + TO + 1, "R7", 1, 8'h00);
    wait_until(c + TO + 3);
    hard(ca, cr);

    wr(12, 8'h01, c);
    wait_until(c + 25);
    wr(12, 8'h00, c2);
    wait_until(c2 + 5);
    wr(12, 8'h01, c2);
    expect_at(c2 + TO, "R7", 1, 8'h01);
    expect_at(c2 + TO + 1, "R7", 1, 8'h00);
    wait_until(c2 + TO + 3);
    hard(ca, cr);

    wr(15, 8'h00, c);
    expect_at(c + TO + 5, "R8", 1, 8'h01);
    expect_at(c + 2 * TO, "R8", 1, 8'h01);
    wait_until(c + 2 * TO + 2);

    wr(12, 8'h03, c);
    wait_until(c + 10);
    wr(11, 8'h5A, c2);
    expect_at(c2 + 1, "R1", 2, 8'h01);
    expect_at(c2 + 1, "R1", 3, 8'h01);
    expect_at(c2 + 2, "R1", 2, 8'h00);
    expect_at(c2 + 2, "R1", 3, 8'h00);
    expect_at(c2 + 2, "R2", 0, 8'h00);
    expect_at(c + TO + 10, "R3", 1, 8'h01);
    wait_until(c + TO + 12);
    wr(12, 8'h02, c); expect_at(c + 1, "R4", 0, 8'h02);

    wr(12, 8'h03, c);
    wait_until(c + 5);
    hard(ca, cr);
    expect_at(cr + 3, "R2", 0, 8'h00);
    expect_at(ca + TO + 10, "R2", 1, 8'h01);
    wait_until(max_due + 2);

    if (sb.size() != 0) begin
      bad += sb.size();
      total += sb.size();
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule